// File: doc/BRIEF.md
# Scalar Single-Precision Compare Flags Unit

This unit compares two IEEE-754 single-precision numbers and turns the outcome into six integer status flags: zero, parity, carry, overflow, sign and auxiliary. Each operand arrives as a wide vector register. Only the lowest 32-bit lane of each register takes part in the compare, and all the other lanes are ignored. One compare is started by a one-cycle `in_valid` strobe. One cycle later the unit writes the new flags and raises a one-cycle write enable.

Any NaN operand, quiet or signaling, gives an unordered result and raises the invalid exception. A subnormal operand raises the denormal exception. Each exception has a mask input. If a raised exception is not masked, the flags are not written and a trap pulse is given instead. The previous flag values stay on the outputs.

Top module: `sfp_cmp_flags`

## Requirements
- R1: Only bits 31..0 of `src_a` and `src_b` are compared. Changing any higher bit changes no output.
- R2: On a flag write, {zero,parity,carry} encodes how a relates to b: unordered = 1,1,1; a greater = 0,0,0; a less = 0,0,1; equal = 1,0,0.
- R3: Every flag write clears overflow, sign and auxiliary to 0.
- R4: An operand is a NaN when its exponent field (bits 30..23) is all ones and its mantissa (bits 22..0) is nonzero. A NaN in either operand makes the result unordered.
- R5: `exc_invalid` is raised for a NaN in either operand, whether quiet (bit 22 set) or signaling (bit 22 clear).
- R6: `exc_denormal` is raised when either operand has a zero exponent field and a nonzero mantissa.
- R7: A raised exception whose mask input is 0 gives `trap`=1 and `flags_we`=0. All six flags keep their previous values.
- R8: A raised exception whose mask input is 1 still reports its exception output. In that case `trap` stays 0 and the flags are written normally.
- R9: +0 and -0 compare equal. Other values are ordered by sign and magnitude: any positive value is above any negative value, and among negative values a larger magnitude is the smaller number. Infinities and subnormals take part in this ordering.
- R10: All outputs are registered. They reflect an operation in the cycle after its `in_valid` edge. A cycle with `in_valid`=0 is followed by `flags_we`, `trap` and both exception outputs at 0, with the flags unchanged. Back-to-back strobes give one write per operation.
- R11: While `rst_n` is 0, all six flags, `flags_we`, both exception outputs and `trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Starts one compare |
| src_a | input | 128 | First vector operand (low lane used) |
| src_b | input | 128 | Second vector operand (low lane used) |
| mask_invalid | input | 1 | 1 masks the invalid exception |
| mask_denormal | input | 1 | 1 masks the denormal exception |
| flags_we | output | 1 | One-cycle pulse when the flags were written |
| flag_zero | output | 1 | Zero flag |
| flag_parity | output | 1 | Parity flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_sign | output | 1 | Sign flag |
| flag_aux | output | 1 | Auxiliary flag |
| exc_invalid | output | 1 | Invalid exception raised by the last operation |
| exc_denormal | output | 1 | Denormal exception raised by the last operation |
| trap | output | 1 | Unmasked exception; flags were not written |

## Verification
Two things can happen in the same cycle: the two exceptions can be raised together, and a masked report can occur while an unmasked exception suppresses the flag write. The bench provokes this with a NaN in one operand and a subnormal in the other, and tries each split of the two mask bits. For each split it checks that both exception outputs are high. It also checks that the trap appears exactly when one of the two masks is clear, and that in that case the flags keep the values from the previous write. Back-to-back strobes check that a trapped operation sitting between two writing operations does not disturb either of them.

// File: rtl/sfp_cmp_pkg.sv
package sfp_cmp_pkg;

  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_LT = 2'd1,
    REL_EQ = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic zero;
    logic denorm;
  } fp_class_t;

  // {zero, parity, carry} produced for each relation (R2)
  function automatic logic [2:0] rel_code(input rel_e r);
    logic [2:0] c;
    case (r)
      REL_UN:  c = 3'b111;
      REL_GT:  c = 3'b000;
      REL_LT:  c = 3'b001;
      default: c = 3'b100;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sfp_lane_classify.sv
module sfp_lane_classify
  import sfp_cmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int LANE_W = 1 + EXP_W + MAN_W
) (
  input  logic [LANE_W-1:0] op,
  output fp_class_t         cls
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             exp_zero;
  logic             man_zero;

  assign exp_f    = op[LANE_W-2 -: EXP_W];
  assign man_f    = op[MAN_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign man_zero = ~|man_f;

  always_comb begin
    cls.sign   = op[LANE_W-1];
    cls.nan    = exp_ones & ~man_zero;
    cls.zero   = exp_zero & man_zero;
    cls.denorm = exp_zero & ~man_zero;
  end

endmodule

// File: rtl/sfp_order_cmp.sv
module sfp_order_cmp
  import sfp_cmp_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  fp_class_t         cls_a,
  input  fp_class_t         cls_b,
  output rel_e              rel
);

  localparam int MAG_W = LANE_W - 1;

  logic [MAG_W-1:0] mag_a;
  logic [MAG_W-1:0] mag_b;
  logic             mag_gt;
  logic             mag_eq;

  assign mag_a  = a[MAG_W-1:0];
  assign mag_b  = b[MAG_W-1:0];
  assign mag_gt = mag_a > mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    if (cls_a.nan || cls_b.nan) begin
      rel = REL_UN;
    end else if (cls_a.zero && cls_b.zero) begin
      rel = REL_EQ;
    end else if (cls_a.sign != cls_b.sign) begin
      rel = cls_a.sign ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (mag_gt) begin
      rel = cls_a.sign ? REL_LT : REL_GT;
    end else begin
      rel = cls_a.sign ? REL_GT : REL_LT;
    end
  end

endmodule

// File: rtl/sfp_flag_regs.sv
module sfp_flag_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       valid,
  input  logic       write_now,
  input  logic       trap_now,
  input  logic       raise_inv,
  input  logic       raise_den,
  input  logic [2:0] zpc_code,
  output logic       flags_we,
  output logic       flag_zero,
  output logic       flag_parity,
  output logic       flag_carry,
  output logic       flag_ovf,
  output logic       flag_sign,
  output logic       flag_aux,
  output logic       exc_invalid,
  output logic       exc_denormal,
  output logic       trap
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_we     <= 1'b0;
      exc_invalid  <= 1'b0;
      exc_denormal <= 1'b0;
      trap         <= 1'b0;
      flag_zero    <= 1'b0;
      flag_parity  <= 1'b0;
      flag_carry   <= 1'b0;
      flag_ovf     <= 1'b0;
      flag_sign    <= 1'b0;
      flag_aux     <= 1'b0;
    end else begin
      flags_we     <= write_now;
      exc_invalid  <= valid & raise_inv;
      exc_denormal <= valid & raise_den;
      trap         <= trap_now;
      if (write_now) begin
        flag_zero   <= zpc_code[2];
        flag_parity <= zpc_code[1];
        flag_carry  <= zpc_code[0];
        flag_ovf    <= 1'b0;
        flag_sign   <= 1'b0;
        flag_aux    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sfp_cmp_flags.sv
module sfp_cmp_flags
  import sfp_cmp_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  input  logic             mask_invalid,
  input  logic             mask_denormal,
  output logic             flags_we,
  output logic             flag_zero,
  output logic             flag_parity,
  output logic             flag_carry,
  output logic             flag_ovf,
  output logic             flag_sign,
  output logic             flag_aux,
  output logic             exc_invalid,
  output logic             exc_denormal,
  output logic             trap
);

  localparam int LANE_W = 1 + EXP_W + MAN_W;
  localparam int N_OPS  = 2;

  logic [LANE_W-1:0] lane [N_OPS];
  fp_class_t         cls  [N_OPS];
  rel_e              rel;
  logic [2:0]        zpc_code;

  // named events for the checker
  logic nan_any;
  logic den_any;
  logic trap_now;
  logic write_now;

  assign lane[0] = src_a[LANE_W-1:0];
  assign lane[1] = src_b[LANE_W-1:0];

  generate
    if (VEC_W > LANE_W) begin : g_upper
      logic unused_upper;
      assign unused_upper = ^{src_a[VEC_W-1:LANE_W], src_b[VEC_W-1:LANE_W]};
    end
    for (genvar k = 0; k < N_OPS; k++) begin : g_cls
      sfp_lane_classify #(
        .EXP_W(EXP_W),
        .MAN_W(MAN_W)
      ) i_cls (
        .op (lane[k]),
        .cls(cls[k])
      );
    end
  endgenerate

  sfp_order_cmp #(
    .LANE_W(LANE_W)
  ) i_order (
    .a    (lane[0]),
    .b    (lane[1]),
    .cls_a(cls[0]),
    .cls_b(cls[1]),
    .rel  (rel)
  );

  assign zpc_code  = rel_code(rel);
  assign nan_any   = cls[0].nan | cls[1].nan;
  assign den_any   = cls[0].denorm | cls[1].denorm;
  assign trap_now  = in_valid & ((nan_any & ~mask_invalid) | (den_any & ~mask_denormal));
  assign write_now = in_valid & ~trap_now;

  sfp_flag_regs i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid       (in_valid),
    .write_now   (write_now),
    .trap_now    (trap_now),
    .raise_inv   (nan_any),
    .raise_den   (den_any),
    .zpc_code    (zpc_code),
    .flags_we    (flags_we),
    .flag_zero   (flag_zero),
    .flag_parity (flag_parity),
    .flag_carry  (flag_carry),
    .flag_ovf    (flag_ovf),
    .flag_sign   (flag_sign),
    .flag_aux    (flag_aux),
    .exc_invalid (exc_invalid),
    .exc_denormal(exc_denormal),
    .trap        (trap)
  );

endmodule

// File: rtl/sfp_cmp_flags_chk.sv
module sfp_cmp_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic nan_any,
  input logic den_any,
  input logic trap_now,
  input logic flags_we,
  input logic flag_zero,
  input logic flag_parity,
  input logic flag_carry,
  input logic flag_ovf,
  input logic flag_sign,
  input logic flag_aux,
  input logic exc_invalid,
  input logic exc_denormal,
  input logic trap
);

  logic [5:0] flag_vec;
  logic [2:0] zpc;
  assign flag_vec = {flag_zero, flag_parity, flag_carry, flag_ovf, flag_sign, flag_aux};
  assign zpc      = {flag_zero, flag_parity, flag_carry};

  p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> (zpc == 3'b111 || zpc == 3'b000 || zpc == 3'b001 || zpc == 3'b100));

  p_clear_osa_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |-> !(flag_ovf || flag_sign || flag_aux));

  p_nan_unordered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_any && !trap_now) |=> (zpc == 3'b111));

  p_nan_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_any) |=> exc_invalid);

  p_denorm_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && den_any) |=> exc_denormal);

  p_trap_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!flags_we && $stable(flag_vec)));

  p_trap_needs_exc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (exc_invalid || exc_denormal));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(flags_we || trap || exc_invalid || exc_denormal));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we |-> $stable(flag_vec));

endmodule

bind sfp_cmp_flags sfp_cmp_flags_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .nan_any     (nan_any),
  .den_any     (den_any),
  .trap_now    (trap_now),
  .flags_we    (flags_we),
  .flag_zero   (flag_zero),
  .flag_parity (flag_parity),
  .flag_carry  (flag_carry),
  .flag_ovf    (flag_ovf),
  .flag_sign   (flag_sign),
  .flag_aux    (flag_aux),
  .exc_invalid (exc_invalid),
  .exc_denormal(exc_denormal),
  .trap        (trap)
);

// File: tb/test_sfp_cmp_flags.sv
`timescale 1ns/1ps
module test_sfp_cmp_flags;

  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic          mask_invalid = 1'b1;
  logic          mask_denormal = 1'b1;
  logic flags_we, flag_zero, flag_parity, flag_carry, flag_ovf, flag_sign, flag_aux;
  logic exc_invalid, exc_denormal, trap;

  int         total = 0;
  int         bad = 0;
  logic [5:0] model_flags = '0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #10 clk = ~clk;

  sfp_cmp_flags i_sfp_cmp_flags (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .mask_invalid(mask_invalid), .mask_denormal(mask_denormal), .flags_we(flags_we),
    .flag_zero(flag_zero), .flag_parity(flag_parity), .flag_carry(flag_carry),
    .flag_ovf(flag_ovf), .flag_sign(flag_sign), .flag_aux(flag_aux),
    .exc_invalid(exc_invalid), .exc_denormal(exc_denormal), .trap(trap)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction

  function automatic logic is_den(input logic [31:0] v);
    return (v[30:23] == 8'h00) && (v[22:0] != 23'd0);
  endfunction

  // monotonic integer key: larger key = larger number, both zeros share one key
  function automatic logic [31:0] fkey(input logic [31:0] v);
    if (v[30:0] == 31'd0) return 32'h8000_0000;
    return v[31] ? ~v : (v | 32'h8000_0000);
  endfunction

  function automatic logic [2:0] ref_code(input logic [31:0] a, input logic [31:0] b);
    if (is_nan(a) || is_nan(b)) return 3'b111;
    if (fkey(a) > fkey(b)) return 3'b000;
    if (fkey(a) < fkey(b)) return 3'b001;
    return 3'b100;
  endfunction

  function automatic logic [31:0] flag_word();
    return {26'd0, flag_zero, flag_parity, flag_carry, flag_ovf, flag_sign, flag_aux};
  endfunction

  function automatic logic [31:0] ctl_word();
    return {28'd0, flags_we, exc_invalid, exc_denormal, trap};
  endfunction

  // drives one operation at a falling edge; checks at the next falling edge
  task automatic run_op(input logic [VW-1:0] a, input logic [VW-1:0] b,
                        input logic mi, input logic md, input string req);
    logic [31:0] la;
    logic [31:0] lb;
    logic        inv, den, trp;
    logic [5:0]  ef;
    la  = a[31:0];
    lb  = b[31:0];
    inv = is_nan(la) | is_nan(lb);
    den = is_den(la) | is_den(lb);
    trp = (inv & ~mi) | (den & ~md);
    ef  = trp ? model_flags : {ref_code(la, lb), 3'b000};
    src_a = a; src_b = b; mask_invalid = mi; mask_denormal = md; in_valid = 1'b1;
    @(negedge clk);
    chk(req, "flags", flag_word(), {26'd0, ef});
    chk(req, "ctl we/inv/den/trap", ctl_word(), {28'd0, ~trp, inv, den, trp});
    model_flags = ef;
  endtask

  task automatic op32(input logic [31:0] a, input logic [31:0] b,
                      input logic mi, input logic md, input string req);
    run_op({96'd0, a}, {96'd0, b}, mi, md, req);
  endtask

  task automatic idle(input int n, input string req);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(req, "idle ctl", ctl_word(), 32'd0);
      chk(req, "idle flags hold", flag_word(), {26'd0, model_flags});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11", "reset flags", flag_word(), 32'd0);
    chk("R11", "reset ctl", ctl_word(), 32'd0);
    rst_n = 1'b1;
    idle(1, "R11");
  endtask

  task automatic t_orders();
    op32(32'h4000_0000, 32'h3F80_0000, 1'b1, 1'b1, "R2 gt");
    op32(32'h3F80_0000, 32'h4000_0000, 1'b1, 1'b1, "R2 lt");
    op32(32'h3F80_0000, 32'h3F80_0000, 1'b1, 1'b1, "R2 eq");
    op32(32'h7FC0_0000, 32'h3F80_0000, 1'b1, 1'b1, "R2 R3 un");
    idle(2, "R10");
  endtask

  task automatic t_upper_lanes();
    run_op({96'hDEAD_BEEF_0123_4567_89AB_CDEF, 32'h3F80_0000},
           {96'h0, 32'h3F80_0000}, 1'b1, 1'b1, "R1 eq");
    run_op({96'h7FC0_0000_7F80_0001_0000_0001, 32'h4000_0000},
           {96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 32'h3F80_0000}, 1'b0, 1'b0, "R1 gt no exc");
    idle(1, "R1");
  endtask

  task automatic t_zero_sign();
    op32(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b1, "R9 +0=-0");
    op32(32'h8000_0000, 32'h0000_0000, 1'b1, 1'b1, "R9 -0=+0");
    op32(32'hBF80_0000, 32'h3F80_0000, 1'b1, 1'b1, "R9 neg<pos");
    op32(32'hC000_0000, 32'hBF80_0000, 1'b1, 1'b1, "R9 -2<-1");
    op32(32'hBF80_0000, 32'hC000_0000, 1'b1, 1'b1, "R9 -1>-2");
    op32(32'h7F80_0000, 32'h7F7F_FFFF, 1'b1, 1'b1, "R9 +inf>max");
    op32(32'hFF80_0000, 32'hFF7F_FFFF, 1'b1, 1'b1, "R9 -inf<-max");
    op32(32'h7F80_0000, 32'h7F80_0000, 1'b1, 1'b1, "R9 inf=inf");
    idle(1, "R9");
  endtask

  task automatic t_nan_kinds();
    op32(32'h7F80_0001, 32'h3F80_0000, 1'b1, 1'b1, "R4 R5 R8 snan masked");
    op32(32'h3F80_0000, 32'hFFC0_0000, 1'b1, 1'b1, "R4 R5 R8 qnan b");
    op32(32'h3F80_0000, 32'h3F80_0000, 1'b1, 1'b1, "R2 setup");
    op32(32'h7FC0_0000, 32'h7F80_0001, 1'b0, 1'b1, "R7 nan unmasked");
    idle(1, "R7");
  endtask

  task automatic t_denormal();
    op32(32'h0000_0001, 32'h0000_0000, 1'b1, 1'b1, "R6 R8 den masked");
    op32(32'h8000_0001, 32'h0000_0000, 1'b1, 1'b1, "R6 R9 -den<0");
    op32(32'h4000_0000, 32'h3F80_0000, 1'b1, 1'b1, "R2 setup");
    op32(32'h0040_0000, 32'h3F80_0000, 1'b1, 1'b0, "R6 R7 den unmasked");
    op32(32'h0040_0000, 32'h3F80_0000, 1'b0, 1'b1, "R6 R8 inv mask irrelevant");
    idle(1, "R6");
  endtask

  task automatic t_mixed_exc();
    op32(32'h3F80_0000, 32'h4000_0000, 1'b1, 1'b1, "R2 setup");
    op32(32'h7FC0_0000, 32'h0000_0001, 1'b1, 1'b1, "R5 R6 R8 both masked");
    op32(32'h7FC0_0000, 32'h0000_0001, 1'b0, 1'b1, "R5 R6 R7 inv open");
    op32(32'h7FC0_0000, 32'h0000_0001, 1'b1, 1'b0, "R5 R6 R7 den open");
    op32(32'h7FC0_0000, 32'h0000_0001, 1'b0, 1'b0, "R5 R6 R7 both open");
    op32(32'hC000_0000, 32'h4000_0000, 1'b0, 1'b0, "R10 back-to-back after trap");
    idle(1, "R10");
  endtask

  task automatic t_sweep();
    logic [31:0] a, b;
    for (int i = 0; i < 200; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      b = lfsr;
      case (a[1:0])
        2'd1: a[30:23] = 8'h00;
        2'd2: a[30:23] = 8'hFF;
        2'd3: a[30:23] = b[30:23];
        default: ;
      endcase
      if (b[3:2] == 2'd0) b[30:23] = 8'h00;
      if (a[5:4] == 2'd0) b[22:0] = a[22:0];
      op32(a, b, lfsr[7], lfsr[9], "R2 R9 sweep");
      if (lfsr[11]) idle(1, "R10 sweep");
    end
    idle(1, "R10");
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    t_orders();
    t_upper_lanes();
    t_zero_sign();
    t_nan_kinds();
    t_denormal();
    t_mixed_exc();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule